// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block is the front stage of a pipelined processor core. It owns the program counter and a six-state controller. The controller reacts to squash requests and back-pressure from the later pipeline stages. In any cycle where it may fetch, it either issues a lookup to the instruction cache or delivers a refilled line. It then hands decode a group of consecutive instructions.

A group begins at the current PC and holds consecutive 4-byte words. It ends at the fetch width or at the last word of the cache line, whichever comes first. Each delivered slot carries its instruction word, its PC, a not-taken predicted next PC and a sequence number drawn from a free-running counter.

A cache miss parks the stage until the cache sends a completion pulse. A completion pulse that arrives in any other state is ignored. A fault on the lookup blocks the stage and raises a trap request.

The cache answers a lookup in the same cycle. `ic_hit` and `ic_fault` are qualified by `ic_req`. `ic_line` always presents the whole line that contains `ic_addr`. The slot outputs, `pc`, `next_pc`, `trap_req` and `fetch_state` are registered and change on the clock edge that ends the deciding cycle.

Top module: `fetch_stage_ctrl`

## Requirements
- R1: After reset, `fetch_state` is 0 (idle), `pc` equals the RESET_PC parameter, `next_pc` is `pc`+4, every slot is invalid and `trap_req` is low.
- R2: States are encoded as idle 0, running 1, blocked 2, squashing 3, miss-wait 4 and refill-ready 5. `ic_req` is high only in idle or running, and only when no squash, ROB-squashing or stall input is high.
- R3: In idle, running, refill-ready or blocked, a commit squash overrides a decode squash. The chosen target, with its two low bits cleared, becomes `pc` and `next_pc` becomes target+4. The state becomes squashing, and no slot is valid on the next cycle.
- R4: In a fetch-eligible state, with no squash pending, the ROB-squashing input alone moves the stage to squashing and leaves `pc` unchanged.
- R5: In a fetch-eligible state, any of the four stall inputs moves the stage to blocked and delivers nothing. Blocked returns to running, without fetching in that cycle, once all four stall inputs are low.
- R6: While blocked, commit and decode squashes are still taken, with the same priority and effect as in R3.
- R7: Squashing returns to running only when both the commit squash and ROB-squashing inputs are low. A decode squash is ignored there. A new commit squash reloads `pc` with its target and the stage stays squashing.
- R8: A miss moves running to miss-wait with `pc` unchanged. An `ic_done` pulse moves miss-wait to refill-ready, and in every other state the pulse has no effect. Refill-ready delivers the group with `ic_req` low and moves to running.
- R9: With w the word index of `pc` in the line, the group size is n = min(FETCH_W, LINE_BYTES/4 − w). Slot i < n is valid with PC `pc`+4i and instruction word w+i of `ic_line`, where word k occupies bits [32k+31:32k]. Slots at index n or above are invalid.
- R10: Each valid slot's predicted next PC is its own PC+4. Slot i's sequence number is the counter value plus i. The counter starts at 0 at reset and advances by n per group.
- R11: After a group, `pc` becomes the old `pc`+4n and `next_pc` becomes that value plus 4.
- R12: A fault on a lookup moves the stage to blocked with `pc` unchanged and no valid slots. It also raises `trap_req` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_squash | input | 1 | Squash request from commit |
| cmt_target | input | ADDR_W | Redirect target from commit |
| dec_squash | input | 1 | Squash request from decode |
| dec_target | input | ADDR_W | Redirect target from decode |
| rob_squashing | input | 1 | Reorder buffer still draining a squash |
| stall_decode | input | 1 | Back-pressure from decode |
| stall_rename | input | 1 | Back-pressure from rename |
| stall_execute | input | 1 | Back-pressure from execute |
| stall_commit | input | 1 | Back-pressure from commit |
| ic_req | output | 1 | Instruction cache lookup this cycle |
| ic_addr | output | ADDR_W | Lookup address (current PC) |
| ic_hit | input | 1 | Lookup hit, same cycle as `ic_req` |
| ic_fault | input | 1 | Lookup faulted, same cycle as `ic_req` |
| ic_line | input | LINE_BYTES*8 | Line containing `ic_addr` |
| ic_done | input | 1 | One-cycle miss completion pulse |
| slot_valid | output | FETCH_W | Per-slot valid |
| slot_inst | output | FETCH_W*32 | Per-slot instruction word |
| slot_pc | output | FETCH_W*ADDR_W | Per-slot PC |
| slot_pred_pc | output | FETCH_W*ADDR_W | Per-slot predicted next PC |
| slot_seq | output | FETCH_W*SEQ_W | Per-slot sequence number |
| pc | output | ADDR_W | Program counter |
| next_pc | output | ADDR_W | Next program counter |
| trap_req | output | 1 | Trap request pulse after a fault |
| fetch_state | output | 3 | Controller state |

## Verification
On every cycle, the assertions check several properties. A stale completion never reaches refill-ready. A lookup only happens from idle or running. A fault always lands in blocked with a trap. A commit squash always lands on its target with no slots. The valid slots always form a prefix. The sequence counter advances by exactly the number of valid slots.

The group contents can only be shown by the bench's scenarios. These include the group size and word selection at every word offset in a line, and the carry across a line boundary. The scenarios also cover priority among simultaneous squash sources, the blocked-to-running release with its idle cycle, and the two-step miss handshake.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_SQUASH = 3'd3,
    ST_MISS   = 3'd4,
    ST_REFILL = 3'd5
  } fstate_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_COMMIT = 2'd1,
    RD_DECODE = 2'd2
  } redir_e;

endpackage

// File: rtl/fetch_fsm.sv
module fetch_fsm
  import fetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmt_sq,
  input  logic    dec_sq,
  input  logic    rob_sq,
  input  logic    stall_any,
  input  logic    ic_hit,
  input  logic    ic_fault,
  input  logic    ic_done,
  output fstate_e state_q,
  output redir_e  redir,
  output logic    deliver,
  output logic    ic_req,
  output logic    trap_q
);

  fstate_e state_d;
  logic    trap_set;

  always_comb begin
    state_d  = state_q;
    redir    = RD_NONE;
    deliver  = 1'b0;
    ic_req   = 1'b0;
    trap_set = 1'b0;
    case (state_q)
      ST_IDLE, ST_RUN, ST_REFILL: begin
        if (cmt_sq) begin
          redir   = RD_COMMIT;
          state_d = ST_SQUASH;
        end else if (dec_sq) begin
          redir   = RD_DECODE;
          state_d = ST_SQUASH;
        end else if (rob_sq) begin
          state_d = ST_SQUASH;
        end else if (stall_any) begin
          state_d = ST_BLOCK;
        end else if (state_q == ST_REFILL) begin
          deliver = 1'b1;
          state_d = ST_RUN;
        end else begin
          ic_req = 1'b1;
          if (ic_fault) begin
            trap_set = 1'b1;
            state_d  = ST_BLOCK;
          end else if (!ic_hit) begin
            state_d = ST_MISS;
          end else begin
            deliver = 1'b1;
            state_d = ST_RUN;
          end
        end
      end
      ST_BLOCK: begin
        if (!stall_any) state_d = ST_RUN;
        if (cmt_sq) begin
          redir   = RD_COMMIT;
          state_d = ST_SQUASH;
        end else if (dec_sq) begin
          redir   = RD_DECODE;
          state_d = ST_SQUASH;
        end else if (rob_sq) begin
          state_d = ST_SQUASH;
        end
      end
      ST_SQUASH: begin
        if (cmt_sq) redir = RD_COMMIT;
        else if (!rob_sq) state_d = ST_RUN;
      end
      ST_MISS: begin
        if (ic_done) state_d = ST_REFILL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trap_q  <= trap_set;
    end
  end

  // R8
  stale_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_done && state_q != ST_MISS) |=> state_q != ST_REFILL);

  // R2
  req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_req |-> (state_q == ST_IDLE || state_q == ST_RUN));

  // R12
  fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req && ic_fault) |=> (trap_q && state_q == ST_BLOCK));

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc
  import fetch_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 32,
  parameter int unsigned          SEQ_W    = 16,
  parameter int unsigned          CNT_W    = 3,
  parameter logic [ADDR_W-1:0]    RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  redir_e            redir,
  input  logic [ADDR_W-1:0] cmt_tgt,
  input  logic [ADDR_W-1:0] dec_tgt,
  input  logic              adv,
  input  logic [CNT_W-1:0]  grp_cnt,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] npc_q,
  output logic [SEQ_W-1:0]  seq_q
);

  logic [ADDR_W-1:0] pc_d;
  logic [SEQ_W-1:0]  seq_d;
  logic              pc_en;
  logic              seq_en;

  always_comb begin
    pc_d   = pc_q;
    seq_d  = seq_q;
    pc_en  = 1'b0;
    seq_en = 1'b0;
    case (redir)
      RD_COMMIT: begin
        pc_d  = {cmt_tgt[ADDR_W-1:2], 2'b00};
        pc_en = 1'b1;
      end
      RD_DECODE: begin
        pc_d  = {dec_tgt[ADDR_W-1:2], 2'b00};
        pc_en = 1'b1;
      end
      default: begin
        if (adv) begin
          pc_d   = pc_q + (ADDR_W'(grp_cnt) << 2);
          seq_d  = seq_q + SEQ_W'(grp_cnt);
          pc_en  = 1'b1;
          seq_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      npc_q <= RESET_PC + ADDR_W'(4);
    end else if (pc_en) begin
      pc_q  <= pc_d;
      npc_q <= pc_d + ADDR_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_q <= '0;
    else if (seq_en) seq_q <= seq_d;
  end

  // R11
  npc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> npc_q == pc_q + ADDR_W'(4));

endmodule

// File: rtl/fetch_group.sv
module fetch_group #(
  parameter int unsigned FETCH_W    = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned INST_W     = 32,
  parameter int unsigned CNT_W      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           pc,
  input  logic [SEQ_W-1:0]            seq,
  input  logic [LINE_BYTES*8-1:0]     line,
  input  logic                        load,
  output logic [CNT_W-1:0]            grp_cnt,
  output logic [FETCH_W-1:0]          slot_valid,
  output logic [FETCH_W*INST_W-1:0]   slot_inst,
  output logic [FETCH_W*ADDR_W-1:0]   slot_pc,
  output logic [FETCH_W*ADDR_W-1:0]   slot_pred_pc,
  output logic [FETCH_W*SEQ_W-1:0]    slot_seq
);

  localparam int unsigned WORDS  = LINE_BYTES / 4;
  localparam int unsigned WIDX_W = $clog2(WORDS);

  logic [WIDX_W-1:0] widx;
  logic [WIDX_W:0]   room;

  assign widx = pc[WIDX_W+1:2];
  assign room = (WIDX_W+1)'(WORDS) - {1'b0, widx};

  always_comb begin
    if (int'(room) < int'(FETCH_W)) grp_cnt = CNT_W'(room);
    else                            grp_cnt = CNT_W'(FETCH_W);
  end

  logic              valid_q [FETCH_W];
  logic [INST_W-1:0] inst_q  [FETCH_W];
  logic [ADDR_W-1:0] pc_q    [FETCH_W];
  logic [ADDR_W-1:0] pred_q  [FETCH_W];
  logic [SEQ_W-1:0]  seq_q   [FETCH_W];

  for (genvar i = 0; i < FETCH_W; i++) begin : g_slot
    logic              vld_d;
    logic [WIDX_W-1:0] wsel;

    assign vld_d = int'(grp_cnt) > i;
    assign wsel  = widx + WIDX_W'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[i] <= 1'b0;
      else        valid_q[i] <= load & vld_d;
    end

    always_ff @(posedge clk) begin
      if (load) begin
        inst_q[i] <= line[wsel*INST_W +: INST_W];
        pc_q[i]   <= pc + ADDR_W'(4 * i);
        pred_q[i] <= pc + ADDR_W'(4 * i + 4);
        seq_q[i]  <= seq + SEQ_W'(i);
      end
    end

    assign slot_valid[i]                    = valid_q[i];
    assign slot_inst[i*INST_W +: INST_W]    = inst_q[i];
    assign slot_pc[i*ADDR_W +: ADDR_W]      = pc_q[i];
    assign slot_pred_pc[i*ADDR_W +: ADDR_W] = pred_q[i];
    assign slot_seq[i*SEQ_W +: SEQ_W]       = seq_q[i];

    if (i > 0) begin : g_prefix
      // R9
      slot_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[i] |-> valid_q[i-1]);
    end
  end

endmodule

// File: rtl/fetch_stage_ctrl.sv
module fetch_stage_ctrl
  import fetch_pkg::*;
#(
  parameter int unsigned       FETCH_W    = 4,
  parameter int unsigned       LINE_BYTES = 64,
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       SEQ_W      = 16,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmt_squash,
  input  logic [ADDR_W-1:0]         cmt_target,
  input  logic                      dec_squash,
  input  logic [ADDR_W-1:0]         dec_target,
  input  logic                      rob_squashing,
  input  logic                      stall_decode,
  input  logic                      stall_rename,
  input  logic                      stall_execute,
  input  logic                      stall_commit,
  output logic                      ic_req,
  output logic [ADDR_W-1:0]         ic_addr,
  input  logic                      ic_hit,
  input  logic                      ic_fault,
  input  logic [LINE_BYTES*8-1:0]   ic_line,
  input  logic                      ic_done,
  output logic [FETCH_W-1:0]        slot_valid,
  output logic [FETCH_W*32-1:0]     slot_inst,
  output logic [FETCH_W*ADDR_W-1:0] slot_pc,
  output logic [FETCH_W*ADDR_W-1:0] slot_pred_pc,
  output logic [FETCH_W*SEQ_W-1:0]  slot_seq,
  output logic [ADDR_W-1:0]         pc,
  output logic [ADDR_W-1:0]         next_pc,
  output logic                      trap_req,
  output logic [2:0]                fetch_state
);

  localparam int unsigned INST_W = 32;
  localparam int unsigned CNT_W  = $clog2(FETCH_W + 1);

  fstate_e          state_q;
  redir_e           redir;
  logic             deliver;
  logic             stall_any;
  logic [CNT_W-1:0] grp_cnt;
  logic [SEQ_W-1:0] seq_q;

  assign stall_any = stall_decode | stall_rename | stall_execute | stall_commit;

  fetch_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmt_sq    (cmt_squash),
    .dec_sq    (dec_squash),
    .rob_sq    (rob_squashing),
    .stall_any (stall_any),
    .ic_hit    (ic_hit),
    .ic_fault  (ic_fault),
    .ic_done   (ic_done),
    .state_q   (state_q),
    .redir     (redir),
    .deliver   (deliver),
    .ic_req    (ic_req),
    .trap_q    (trap_req)
  );

  fetch_pc #(
    .ADDR_W   (ADDR_W),
    .SEQ_W    (SEQ_W),
    .CNT_W    (CNT_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .redir   (redir),
    .cmt_tgt (cmt_target),
    .dec_tgt (dec_target),
    .adv     (deliver),
    .grp_cnt (grp_cnt),
    .pc_q    (pc),
    .npc_q   (next_pc),
    .seq_q   (seq_q)
  );

  fetch_group #(
    .FETCH_W    (FETCH_W),
    .LINE_BYTES (LINE_BYTES),
    .ADDR_W     (ADDR_W),
    .SEQ_W      (SEQ_W),
    .INST_W     (INST_W),
    .CNT_W      (CNT_W)
  ) u_grp (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc           (pc),
    .seq          (seq_q),
    .line         (ic_line),
    .load         (deliver),
    .grp_cnt      (grp_cnt),
    .slot_valid   (slot_valid),
    .slot_inst    (slot_inst),
    .slot_pc      (slot_pc),
    .slot_pred_pc (slot_pred_pc),
    .slot_seq     (slot_seq)
  );

  assign ic_addr     = pc;
  assign fetch_state = state_q;

  // R3
  cmt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_squash && (state_q == ST_IDLE || state_q == ST_RUN ||
                    state_q == ST_REFILL || state_q == ST_BLOCK))
    |=> (pc == {$past(cmt_target[ADDR_W-1:2]), 2'b00} &&
         slot_valid == '0 && state_q == ST_SQUASH));

  // R10
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> seq_q == $past(seq_q) + SEQ_W'($countones(slot_valid)));

endmodule

// File: tb/fetch_stage_ctrl_test.sv
`timescale 1ns/1ps
module fetch_stage_ctrl_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmt_squash, dec_squash, rob_squashing;
  logic [31:0]  cmt_target, dec_target;
  logic         stall_decode, stall_rename, stall_execute, stall_commit;
  logic         ic_req, ic_hit, ic_fault, ic_done;
  logic [31:0]  ic_addr;
  logic [511:0] ic_line;
  logic [3:0]   slot_valid;
  logic [127:0] slot_inst, slot_pc, slot_pred_pc;
  logic [63:0]  slot_seq;
  logic [31:0]  pc, next_pc;
  logic         trap_req;
  logic [2:0]   fetch_state;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] exp_pc;
  logic [15:0] exp_seq;

  always #2 clk = ~clk;

  fetch_stage_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cmt_squash(cmt_squash), .cmt_target(cmt_target),
    .dec_squash(dec_squash), .dec_target(dec_target),
    .rob_squashing(rob_squashing),
    .stall_decode(stall_decode), .stall_rename(stall_rename),
    .stall_execute(stall_execute), .stall_commit(stall_commit),
    .ic_req(ic_req), .ic_addr(ic_addr), .ic_hit(ic_hit), .ic_fault(ic_fault),
    .ic_line(ic_line), .ic_done(ic_done),
    .slot_valid(slot_valid), .slot_inst(slot_inst), .slot_pc(slot_pc),
    .slot_pred_pc(slot_pred_pc), .slot_seq(slot_seq),
    .pc(pc), .next_pc(next_pc), .trap_req(trap_req), .fetch_state(fetch_state)
  );

  // cache model: word k of a line holds a tag derived from its own address
  always_comb begin
    for (int k = 0; k < 16; k++)
      ic_line[k*32 +: 32] = 32'hC0DE_0000 ^ ({ic_addr[31:6], 6'b0} + 32'(4 * k));
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cmt_squash = 0; dec_squash = 0; rob_squashing = 0;
    stall_decode = 0; stall_rename = 0; stall_execute = 0; stall_commit = 0;
    ic_done = 0; ic_fault = 0; ic_hit = 1;
  endtask

  // check a delivered group at exp_pc, then advance the model
  task automatic check_group();
    int w, n;
    w = int'(exp_pc[5:2]);
    n = (16 - w < 4) ? 16 - w : 4;
    for (int i = 0; i < 4; i++) begin
      chk("R9 slot valid", 64'(slot_valid[i]), 64'(i < n));
      if (i < n) begin
        chk("R9 slot pc", 64'(slot_pc[i*32 +: 32]), 64'(exp_pc + 32'(4 * i)));
        chk("R9 slot inst", 64'(slot_inst[i*32 +: 32]),
            64'(32'hC0DE_0000 ^ (exp_pc + 32'(4 * i))));
        chk("R10 pred pc", 64'(slot_pred_pc[i*32 +: 32]), 64'(exp_pc + 32'(4 * i + 4)));
        chk("R10 seq", 64'(slot_seq[i*16 +: 16]), 64'(exp_seq + 16'(i)));
      end
    end
    exp_pc  = exp_pc + 32'(4 * n);
    exp_seq = exp_seq + 16'(n);
    chk("R11 pc after group", 64'(pc), 64'(exp_pc));
    chk("R11 next_pc after group", 64'(next_pc), 64'(exp_pc + 32'd4));
  endtask

  task automatic squash_to(input logic [31:0] tgt);
    cmt_squash = 1; cmt_target = tgt;
    step();
    exp_pc = {tgt[31:2], 2'b00};
    chk("R3 state squashing", 64'(fetch_state), 64'd3);
    chk("R3 pc target", 64'(pc), 64'(exp_pc));
    chk("R3 next_pc", 64'(next_pc), 64'(exp_pc + 32'd4));
    chk("R3 no slots", 64'(slot_valid), 64'd0);
    cmt_squash = 0;
    step();
    chk("R7 back to running", 64'(fetch_state), 64'd1);
    chk("R7 no slots on release", 64'(slot_valid), 64'd0);
    step();
    check_group();
  endtask

  initial begin
    rst_n = 0; cmt_target = 0; dec_target = 0;
    quiet();
    exp_seq = 0;
    repeat (3) @(negedge clk);
    chk("R1 state idle", 64'(fetch_state), 64'd0);
    chk("R1 pc reset", 64'(pc), 64'd0);
    chk("R1 next_pc reset", 64'(next_pc), 64'd4);
    chk("R1 slots invalid", 64'(slot_valid), 64'd0);
    chk("R1 trap low", 64'(trap_req), 64'd0);
    rst_n = 1;

    // R9 sweep over every word offset in a line, squash from idle first
    for (int w = 0; w < 16; w++) squash_to(32'h2000 + 32'(4 * w));
    // R3 low address bits dropped
    squash_to(32'h3007);

    // R9 R11 continuous fetch across a line boundary
    squash_to(32'h4038);
    step(); check_group();
    step(); check_group();

    // R3 commit wins over decode
    cmt_squash = 1; cmt_target = 32'h5000; dec_squash = 1; dec_target = 32'h6000;
    step();
    chk("R3 commit priority pc", 64'(pc), 64'h5000);
    exp_pc = 32'h5000;
    // R7 decode squash ignored in squashing while ROB drains
    cmt_squash = 0; rob_squashing = 1; dec_target = 32'h6100;
    step();
    chk("R7 hold while rob squashing", 64'(fetch_state), 64'd3);
    chk("R7 decode ignored", 64'(pc), 64'h5000);
    rob_squashing = 0;
    step();
    chk("R7 release ignores decode", 64'(fetch_state), 64'd1);
    chk("R7 pc kept", 64'(pc), 64'h5000);
    dec_squash = 0;
    step(); check_group();

    // R3 decode squash alone
    dec_squash = 1; dec_target = 32'h6000;
    step();
    chk("R3 decode target", 64'(pc), 64'h6000);
    chk("R3 decode squashing", 64'(fetch_state), 64'd3);
    dec_squash = 0; rob_squashing = 1;
    step();
    cmt_squash = 1; cmt_target = 32'h7000;
    step();
    chk("R7 commit retarget", 64'(pc), 64'h7000);
    chk("R7 stays squashing", 64'(fetch_state), 64'd3);
    exp_pc = 32'h7000;
    cmt_squash = 0; rob_squashing = 0;
    step();
    step(); check_group();

    // R4 rob squashing alone
    rob_squashing = 1;
    step();
    chk("R4 state squashing", 64'(fetch_state), 64'd3);
    chk("R4 pc unchanged", 64'(pc), 64'(exp_pc));
    chk("R4 no slots", 64'(slot_valid), 64'd0);
    rob_squashing = 0;
    step(); step(); check_group();

    // R5 each stall source
    for (int s = 0; s < 4; s++) begin
      stall_decode = (s == 0); stall_rename = (s == 1);
      stall_execute = (s == 2); stall_commit = (s == 3);
      #1 chk("R2 no request while stalled", 64'(ic_req), 64'd0);
      step();
      chk("R5 blocked", 64'(fetch_state), 64'd2);
      chk("R5 no slots", 64'(slot_valid), 64'd0);
      chk("R5 pc held", 64'(pc), 64'(exp_pc));
      step();
      chk("R5 still blocked", 64'(fetch_state), 64'd2);
      quiet();
      step();
      chk("R5 released", 64'(fetch_state), 64'd1);
      chk("R5 no fetch on release", 64'(slot_valid), 64'd0);
      step(); check_group();
    end

    // R6 squash while blocked
    stall_rename = 1;
    step();
    dec_squash = 1; dec_target = 32'h8000;
    step();
    chk("R6 squash from blocked", 64'(fetch_state), 64'd3);
    chk("R6 pc target", 64'(pc), 64'h8000);
    exp_pc = 32'h8000;
    quiet();
    step(); step(); check_group();

    // R8 miss handshake
    ic_hit = 0;
    #1 chk("R2 request in running", 64'(ic_req), 64'd1);
    step();
    chk("R8 miss wait", 64'(fetch_state), 64'd4);
    chk("R8 pc held", 64'(pc), 64'(exp_pc));
    chk("R8 no slots", 64'(slot_valid), 64'd0);
    step();
    chk("R8 wait without pulse", 64'(fetch_state), 64'd4);
    ic_done = 1;
    step();
    chk("R8 refill ready", 64'(fetch_state), 64'd5);
    ic_done = 0;
    #1 chk("R8 no request in refill", 64'(ic_req), 64'd0);
    step();
    chk("R8 back to running", 64'(fetch_state), 64'd1);
    check_group();
    // R8 stale pulses
    ic_hit = 1; ic_done = 1;
    step();
    chk("R8 stale pulse in running", 64'(fetch_state), 64'd1);
    check_group();
    stall_commit = 1;
    step();
    chk("R8 stale blocked enter", 64'(fetch_state), 64'd2);
    step();
    chk("R8 stale pulse in blocked", 64'(fetch_state), 64'd2);
    quiet();
    step(); step(); check_group();

    // R12 fault
    ic_fault = 1;
    step();
    chk("R12 blocked", 64'(fetch_state), 64'd2);
    chk("R12 trap raised", 64'(trap_req), 64'd1);
    chk("R12 pc held", 64'(pc), 64'(exp_pc));
    chk("R12 no slots", 64'(slot_valid), 64'd0);
    ic_fault = 0;
    step();
    chk("R12 trap one cycle", 64'(trap_req), 64'd0);
    step(); check_group();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule